// File: doc/BRIEF.md
# Alignment exception state capture

This block sits beside the data-access stage of a simple 32-bit processor pipeline. It decides whether a data access is misaligned. When a valid access is misaligned, it performs the register updates for exception entry on one clock edge. It loads a fault-address register with the effective address of the access. It assembles a fault-information word from fields of the faulting instruction word, and the fields chosen depend on whether the instruction uses indexed or immediate-displacement addressing. It saves the old machine state and the faulting instruction address. It writes a rewritten machine state. In the cycle after that edge it raises a one-cycle request that tells fetch to go to the exception vector.

Bit numbers in the requirements are big-endian: bit 0 is the most significant bit of a 32-bit word. In port vectors, bit `[31-n]` is big-endian bit n. The base-register field is copied from the instruction for every access, so the block takes no update-form input. An access with reservation that is misaligned still takes the exception. A separate flag marks that case so that the handler treats it as a programming error and does not emulate the access.

Top module: `align_exc_capture`

## Requirements
- R1: The access size encoding is 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. An access is misaligned when any of its address low bits (`acc_addr[size-1:0]`) is set. A byte access is never misaligned.
- R2: When an exception is taken, `fault_addr` is loaded with `acc_addr`.
- R3: When an exception is taken, `fault_info` big-endian bits 0–14 are cleared. Bits 22–26 take instruction bits 6–10, and bits 27–31 take instruction bits 11–15, whatever the addressing form.
- R4: When `indexed` is 1, `fault_info` bits 15–16 take instruction bits 29–30, bit 17 takes instruction bit 25, and bits 18–21 take instruction bits 21–24.
- R5: When `indexed` is 0, `fault_info` bits 15–16 are cleared, bit 17 takes instruction bit 5, and bits 18–21 take instruction bits 1–4.
- R6: When an exception is taken, `new_state` becomes `cur_state` with these big-endian bits cleared: 13 (power save), 16 (external interrupt enable), 17 (user mode), 18 (floating point), 21 (single step), 22 (branch trace), 26 (instruction translate), 27 (data translate) and 30 (recoverable). Bit 31 (little-endian mode) takes `cur_state` bit 15 (the interrupt little-endian bit). Every other bit keeps its value.
- R7: When an exception is taken, `save_pc` is loaded with `cur_pc` and `save_state` with `cur_state`.
- R8: `exc_taken` is high for exactly the cycle after each edge on which `acc_valid` was high with a misaligned access. Back-to-back faults keep it high.
- R9: When an exception is taken, `resv_err` is loaded with `reserve_acc`. An access with reservation that is misaligned still takes the exception.
- R10: On an edge with no exception (either `acc_valid` low, or an aligned access), every output register holds its value, including when a misaligned address is presented with `acc_valid` low.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | ADDR_W | Effective address of the access |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| instr | input | 32 | Instruction word of the access |
| indexed | input | 1 | 1 = indexed addressing, 0 = immediate displacement |
| reserve_acc | input | 1 | The access is a load or store with reservation |
| cur_pc | input | ADDR_W | Address of the faulting instruction |
| cur_state | input | 32 | Current machine state |
| fault_addr | output | ADDR_W | Captured effective address |
| fault_info | output | 32 | Fault-information word built from the instruction |
| new_state | output | 32 | Machine state written on exception entry |
| save_pc | output | ADDR_W | Saved instruction address |
| save_state | output | 32 | Saved old machine state |
| resv_err | output | 1 | The last taken fault was an access with reservation |
| exc_taken | output | 1 | One-cycle redirect request to the exception vector |

## Verification
The bench builds the block with its default `ADDR_W` of 32. With that width, address patterns with the high bit set sit next to low-bit misalignments of every size, so a truncated or shifted capture path shows up. The scoreboard keeps its own model of every output register. It drives byte, halfword, word and doubleword accesses at aligned and misaligned offsets, both addressing forms with contrasting instruction patterns, machine states of all ones and all zeros, accesses with reservation, and invalid accesses. Back-to-back faults are included, and they show whether the redirect pulse stretches and the captured fields change on consecutive edges.

// File: rtl/align_exc_pkg.sv
package align_exc_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SIZE_W = 2;

  // machine-state bit indices in vector (little) order: index = 31 - big-endian bit
  localparam int unsigned MS_POW = 18;
  localparam int unsigned MS_ILE = 16;
  localparam int unsigned MS_EE  = 15;
  localparam int unsigned MS_PR  = 14;
  localparam int unsigned MS_FP  = 13;
  localparam int unsigned MS_SE  = 10;
  localparam int unsigned MS_BE  = 9;
  localparam int unsigned MS_IR  = 5;
  localparam int unsigned MS_DR  = 4;
  localparam int unsigned MS_RI  = 1;
  localparam int unsigned MS_LE  = 0;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } acc_size_e;

  typedef enum logic {
    FORM_IMM   = 1'b0,
    FORM_INDEX = 1'b1
  } addr_form_e;

  function automatic logic [WORD_W-1:0] entry_clear_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    m[MS_POW] = 1'b1;
    m[MS_EE]  = 1'b1;
    m[MS_PR]  = 1'b1;
    m[MS_FP]  = 1'b1;
    m[MS_SE]  = 1'b1;
    m[MS_BE]  = 1'b1;
    m[MS_IR]  = 1'b1;
    m[MS_DR]  = 1'b1;
    m[MS_RI]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/align_misalign_chk.sv
module align_misalign_chk
  import align_exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              misaligned
);

  localparam int unsigned NUM_SIZES = 1 << SIZE_W;

  logic [NUM_SIZES-1:0] low_bits_set;

  genvar k;
  generate
    for (k = 0; k < NUM_SIZES; k++) begin : g_size
      if (k == 0) begin : g_byte
        assign low_bits_set[k] = 1'b0;
      end else begin : g_wide
        assign low_bits_set[k] = |addr[k-1:0];
      end
    end
  endgenerate

  always_comb begin
    misaligned = low_bits_set[size];
  end

  logic unused_addr_hi;
  assign unused_addr_hi = ^addr[ADDR_W-1:NUM_SIZES-1];

endmodule

// File: rtl/align_status_build.sv
module align_status_build
  import align_exc_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic              indexed,
  output logic [WORD_W-1:0] info
);

  logic [1:0] ext_field;
  logic       mid_bit;
  logic [3:0] op_field;
  logic [4:0] reg_field;
  logic [4:0] base_field;

  always_comb begin
    reg_field  = instr[25:21];
    base_field = instr[20:16];
    if (addr_form_e'(indexed) == FORM_INDEX) begin
      ext_field = instr[2:1];
      mid_bit   = instr[6];
      op_field  = instr[10:7];
    end else begin
      ext_field = 2'b00;
      mid_bit   = instr[26];
      op_field  = instr[30:27];
    end
  end

  always_comb begin
    info        = '0;
    info[16:15] = ext_field;
    info[14]    = mid_bit;
    info[13:10] = op_field;
    info[9:5]   = reg_field;
    info[4:0]   = base_field;
  end

  logic unused_instr;
  assign unused_instr = ^{instr[31], instr[15:11], instr[5:3], instr[0]};

endmodule

// File: rtl/align_state_rewrite.sv
module align_state_rewrite
  import align_exc_pkg::*;
(
  input  logic [WORD_W-1:0] cur_state,
  output logic [WORD_W-1:0] entry_state
);

  logic [WORD_W-1:0] clr_mask;

  always_comb begin
    clr_mask           = entry_clear_mask();
    entry_state        = cur_state & ~clr_mask;
    entry_state[MS_LE] = cur_state[MS_ILE];
  end

endmodule

// File: rtl/align_exc_capture.sv
module align_exc_capture
  import align_exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [WORD_W-1:0] instr,
  input  logic              indexed,
  input  logic              reserve_acc,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [WORD_W-1:0] cur_state,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [WORD_W-1:0] fault_info,
  output logic [WORD_W-1:0] new_state,
  output logic [ADDR_W-1:0] save_pc,
  output logic [WORD_W-1:0] save_state,
  output logic              resv_err,
  output logic              exc_taken
);

  logic              misaligned;
  logic              take_exc;
  logic [WORD_W-1:0] info_built;
  logic [WORD_W-1:0] state_built;

  logic [ADDR_W-1:0] fault_addr_q, fault_addr_d;
  logic [WORD_W-1:0] fault_info_q, fault_info_d;
  logic [WORD_W-1:0] new_state_q,  new_state_d;
  logic [ADDR_W-1:0] save_pc_q,    save_pc_d;
  logic [WORD_W-1:0] save_state_q, save_state_d;
  logic              resv_err_q,   resv_err_d;
  logic              exc_taken_q,  exc_taken_d;

  align_misalign_chk #(.ADDR_W(ADDR_W)) u_mis (
    .addr       (acc_addr),
    .size       (acc_size),
    .misaligned (misaligned)
  );

  align_status_build u_info (
    .instr   (instr),
    .indexed (indexed),
    .info    (info_built)
  );

  align_state_rewrite u_state (
    .cur_state   (cur_state),
    .entry_state (state_built)
  );

  assign take_exc = acc_valid & misaligned;

  always_comb begin
    fault_addr_d = fault_addr_q;
    fault_info_d = fault_info_q;
    new_state_d  = new_state_q;
    save_pc_d    = save_pc_q;
    save_state_d = save_state_q;
    resv_err_d   = resv_err_q;
    exc_taken_d  = take_exc;
    if (take_exc) begin
      fault_addr_d = acc_addr;
      fault_info_d = info_built;
      new_state_d  = state_built;
      save_pc_d    = cur_pc;
      save_state_d = cur_state;
      resv_err_d   = reserve_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr_q <= '0;
      fault_info_q <= '0;
      new_state_q  <= '0;
      save_pc_q    <= '0;
      save_state_q <= '0;
      resv_err_q   <= 1'b0;
    end else if (take_exc) begin
      fault_addr_q <= fault_addr_d;
      fault_info_q <= fault_info_d;
      new_state_q  <= new_state_d;
      save_pc_q    <= save_pc_d;
      save_state_q <= save_state_d;
      resv_err_q   <= resv_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_taken_q <= 1'b0;
    end else begin
      exc_taken_q <= exc_taken_d;
    end
  end

  assign fault_addr = fault_addr_q;
  assign fault_info = fault_info_q;
  assign new_state  = new_state_q;
  assign save_pc    = save_pc_q;
  assign save_state = save_state_q;
  assign resv_err   = resv_err_q;
  assign exc_taken  = exc_taken_q;

endmodule

// File: rtl/align_exc_capture_chk.sv
module align_exc_capture_chk
  import align_exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [SIZE_W-1:0] acc_size,
  input logic              reserve_acc,
  input logic [ADDR_W-1:0] cur_pc,
  input logic [WORD_W-1:0] cur_state,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [WORD_W-1:0] fault_info,
  input logic [WORD_W-1:0] new_state,
  input logic [ADDR_W-1:0] save_pc,
  input logic [WORD_W-1:0] save_state,
  input logic              resv_err,
  input logic              exc_taken
);

  logic bad_access;
  assign bad_access = acc_valid &&
    ((acc_size == 2'd1 && acc_addr[0]) ||
     (acc_size == 2'd2 && (acc_addr[1:0] != 2'b00)) ||
     (acc_size == 2'd3 && (acc_addr[2:0] != 3'b000)));

  // R8
  redirect_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> exc_taken);

  // R1
  no_redirect_when_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_access |=> !exc_taken);

  // R2
  addr_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> fault_addr == $past(acc_addr));

  // R3
  info_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> fault_info[31:17] == 15'd0);

  // R6
  entry_state_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (!new_state[15] && !new_state[14] && !new_state[5] && !new_state[4]));

  // R7
  saved_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> (save_pc == $past(cur_pc) && save_state == $past(cur_state)));

  // R9
  resv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> resv_err == $past(reserve_acc));

  // R10
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_access |=> ($stable(fault_addr) && $stable(fault_info) && $stable(new_state) &&
                     $stable(save_pc) && $stable(save_state) && $stable(resv_err)));

endmodule

bind align_exc_capture align_exc_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .acc_size    (acc_size),
  .reserve_acc (reserve_acc),
  .cur_pc      (cur_pc),
  .cur_state   (cur_state),
  .fault_addr  (fault_addr),
  .fault_info  (fault_info),
  .new_state   (new_state),
  .save_pc     (save_pc),
  .save_state  (save_state),
  .resv_err    (resv_err),
  .exc_taken   (exc_taken)
);

// File: tb/align_exc_capture_tb.sv
module align_exc_capture_tb;

  localparam int unsigned AW = 32;

  typedef struct {
    logic [AW-1:0] fa;
    logic [31:0]   fi;
    logic [31:0]   ns;
    logic [AW-1:0] sp;
    logic [31:0]   ss;
    logic          re;
    logic          tk;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic [31:0]   instr;
  logic          indexed;
  logic          reserve_acc;
  logic [AW-1:0] cur_pc;
  logic [31:0]   cur_state;
  logic [AW-1:0] fault_addr;
  logic [31:0]   fault_info;
  logic [31:0]   new_state;
  logic [AW-1:0] save_pc;
  logic [31:0]   save_state;
  logic          resv_err;
  logic          exc_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];
  exp_t m;

  always #4 clk = ~clk;

  align_exc_capture #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .instr(instr), .indexed(indexed), .reserve_acc(reserve_acc),
    .cur_pc(cur_pc), .cur_state(cur_state), .fault_addr(fault_addr),
    .fault_info(fault_info), .new_state(new_state), .save_pc(save_pc),
    .save_state(save_state), .resv_err(resv_err), .exc_taken(exc_taken)
  );

  function automatic logic be(logic [31:0] w, int n);
    return w[31-n];
  endfunction

  function automatic logic [31:0] exp_info(logic [31:0] w, logic idx);
    logic [31:0] r;
    r = '0;
    r[31-15] = idx ? be(w, 29) : 1'b0;
    r[31-16] = idx ? be(w, 30) : 1'b0;
    r[31-17] = idx ? be(w, 25) : be(w, 5);
    for (int k = 0; k < 4; k++) r[31-(18+k)] = idx ? be(w, 21+k) : be(w, 1+k);
    for (int k = 0; k < 5; k++) r[31-(22+k)] = be(w, 6+k);
    for (int k = 0; k < 5; k++) r[31-(27+k)] = be(w, 11+k);
    return r;
  endfunction

  function automatic logic [31:0] exp_state(logic [31:0] s);
    logic [31:0] r;
    int clr[9] = '{13, 16, 17, 18, 21, 22, 26, 27, 30};
    r = s;
    foreach (clr[i]) r[31-clr[i]] = 1'b0;
    r[31-31] = be(s, 15);
    return r;
  endfunction

  function automatic bit exp_mis(logic [AW-1:0] a, logic [1:0] sz);
    case (sz)
      2'd0: return 1'b0;
      2'd1: return a[0];
      2'd2: return a[1:0] != 0;
      default: return a[2:0] != 0;
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [AW-1:0] a, logic [1:0] sz,
                       logic [31:0] w, logic idx, logic rv,
                       logic [AW-1:0] pc, logic [31:0] st);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; instr = w;
    indexed = idx; reserve_acc = rv; cur_pc = pc; cur_state = st;
    m.tk  = v && exp_mis(a, sz);
    m.tag = tag;
    if (m.tk) begin
      m.fa = a; m.fi = exp_info(w, idx); m.ns = exp_state(st);
      m.sp = pc; m.ss = st; m.re = rv;
    end
    q.push_back(m);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "exc_taken",  64'(exc_taken),  64'(e.tk));
        cmp(e.tag, "fault_addr", 64'(fault_addr), 64'(e.fa));
        cmp(e.tag, "fault_info", 64'(fault_info), 64'(e.fi));
        cmp(e.tag, "new_state",  64'(new_state),  64'(e.ns));
        cmp(e.tag, "save_pc",    64'(save_pc),    64'(e.sp));
        cmp(e.tag, "save_state", 64'(save_state), 64'(e.ss));
        cmp(e.tag, "resv_err",   64'(resv_err),   64'(e.re));
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = 0; acc_size = 0; instr = 0;
    indexed = 0; reserve_acc = 0; cur_pc = 0; cur_state = 0;
    m = '{fa:0, fi:0, ns:0, sp:0, ss:0, re:0, tk:0, tag:""};
    #18;
    // R11: outputs are zero during reset
    cmp("R11", "reset outputs",
        64'({fault_addr, fault_info} | {save_pc, save_state} | {new_state, 30'd0, resv_err, exc_taken}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: byte never faults, aligned sizes do not fault
    drive("R1 byte odd",    1, 32'h8000_0003, 2'd0, 32'hFFFF_FFFF, 1, 0, 32'h100, 32'hFFFF_FFFF);
    drive("R1 half even",   1, 32'h8000_0002, 2'd1, 32'hFFFF_FFFF, 1, 0, 32'h104, 32'hFFFF_FFFF);
    drive("R1 word aligned",1, 32'h0000_0100, 2'd2, 32'hFFFF_FFFF, 1, 0, 32'h108, 32'hFFFF_FFFF);
    drive("R1 dbl aligned", 1, 32'h0000_0108, 2'd3, 32'hFFFF_FFFF, 1, 0, 32'h10C, 32'hFFFF_FFFF);
    // R2 R4 R6 R7: half odd, indexed, all-ones state
    drive("R4 half odd idx",1, 32'h8000_0001, 2'd1, 32'hA5A5_5A5C, 1, 0, 32'h200, 32'hFFFF_FFFF);
    // R10: invalid misaligned access ignored
    drive("R10 invalid",    0, 32'h0000_0003, 2'd2, 32'h1234_5678, 0, 1, 32'h204, 32'h0000_0000);
    drive("R10 aligned",    1, 32'h0000_0004, 2'd2, 32'h1234_5678, 0, 1, 32'h208, 32'h0000_0000);
    // R5 R3: word misaligned, immediate form
    drive("R5 word imm",    1, 32'hDEAD_BEE2, 2'd2, 32'h7FFF_FFFE, 0, 0, 32'h300, 32'h0001_0000);
    drive("R8 idle",        0, 32'h0, 2'd0, 32'h0, 0, 0, 32'h0, 32'h0);
    // R9: reservation misaligned, then back-to-back faults for R8
    drive("R9 resv word",   1, 32'h0000_1001, 2'd2, 32'h8000_0001, 1, 1, 32'h400, 32'h5555_5555);
    drive("R8 b2b dbl",     1, 32'h0000_2004, 2'd3, 32'hFFFF_FFFF, 0, 0, 32'h404, 32'hAAAA_AAAA);
    drive("R3 b2b half",    1, 32'hFFFF_FFFF, 2'd1, 32'h03FF_F800, 0, 0, 32'h408, 32'hFFFE_FFFF);
    drive("R6 ile clear",   1, 32'h0000_0006, 2'd2, 32'h0000_0000, 1, 0, 32'h40C, 32'hFFFF_0001);
    drive("R10 tail",       0, 32'h0000_0001, 2'd1, 32'hFFFF_FFFF, 1, 1, 32'h500, 32'h0);
    drive("R10 tail2",      1, 32'h0000_0001, 2'd0, 32'hFFFF_FFFF, 1, 1, 32'h504, 32'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule